// File: doc/BRIEF.md
# Keyed Software Reset Request Unit

This block protects a whole-chip software reset from stray writes. Firmware issues byte writes on a single-cycle register write port (strobe, address, data). Before a write to the reset control register is accepted, firmware has to write a fixed series of three byte values, in order, to a separate key register. Once the series is complete the reset control register is unlocked for exactly one write. If that write carries FFh, the block raises a one-cycle reset request toward the chip's reset sequencer.

The unlock tracker follows the key writes and falls back to its idle state as soon as a key write breaks the series; a breaking write that equals the first key value begins a fresh series at once. The permission is used up by the next write to the reset control register, whatever value it carries. After it has fired, the reset control register holds FFh until the chip reset, which is the synchronous `rst` input of this block, clears it to 00h and relocks the unit. The block does not stretch the reset itself.

Top module: `swr_unlock_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sw_rst_req` is 0, the unit is locked and the reset control register holds 00h; no write of FFh to address E7h fires until a full key series has been written after reset.
- R2: Writes to the key register (address F7h) of 55h, then AAh, then 5Ah unlock the reset control register; any other value in any of the three positions leaves it locked.
- R3: A key register write that does not match the next expected key value returns the tracker to idle, except that a write of 55h always leaves the tracker having matched the first key, so a new series can continue from it.
- R4: Writes to addresses other than F7h and E7h have no effect, and writes to E7h while locked are ignored: they raise no request and do not disturb a key series in progress.
- R5: A write of FFh to address E7h while unlocked makes `sw_rst_req` high in the cycle after the write for exactly one cycle.
- R6: The unlock is consumed by the next write to E7h of any value; a value other than FFh raises no request, and a later FFh write needs a new key series.
- R7: After a request has fired, the reset control register holds FFh and no further request is raised, even after a new key series, until `rst` is applied.
- R8: Applying `rst` discards any unlock or partial key series.
- R9: Any cycle with `wr_en` low is not a write, whatever `wr_addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| sw_rst_req | output | 1 | One-cycle software reset request to the reset sequencer |

## Verification
On every cycle the assertions check that a request lasts one cycle and follows an unlocked FFh write to E7h, that the unlocked state is reached only from the last key stage, that a write to E7h always relocks, that other cycles leave the tracker still, and that a fired register stays fired with no second request. Which exact byte values open the lock can only be shown by the bench, which sweeps all 256 values through each key position and through the unlocked reset write. The bench scenarios also show restart on a repeated first key, consumption by a non-FFh write, the effect of the strobe, and the loss of the unlock on `rst`.

// File: rtl/swr_pkg.sv
package swr_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned KEY_LEN = 3;

    localparam logic [ADDR_W-1:0] KEY_ADDR_DEF = 8'hF7;
    localparam logic [ADDR_W-1:0] RST_ADDR_DEF = 8'hE7;
    localparam logic [DATA_W-1:0] FIRE_VAL_DEF = 8'hFF;

    // key i sits in bits [i*DATA_W +: DATA_W]; first key in the low byte
    localparam logic [KEY_LEN*DATA_W-1:0] KEY_SEQ_DEF = {8'h5A, 8'hAA, 8'h55};

    // one decoded register write
    typedef struct packed {
        logic              key_wr;
        logic              rst_wr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic logic [DATA_W-1:0] key_byte(
        input logic [KEY_LEN*DATA_W-1:0] seq,
        input int unsigned               idx
    );
        return seq[idx*DATA_W +: DATA_W];
    endfunction

endpackage

// File: rtl/swr_wr_decode.sv
module swr_wr_decode
    import swr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF,
    parameter logic [ADDR_W-1:0] RST_ADDR = RST_ADDR_DEF
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd.key_wr = wr_en && (wr_addr == KEY_ADDR);
        cmd.rst_wr = wr_en && (wr_addr == RST_ADDR);
        cmd.data   = wr_data;
    end

    initial begin
        if (KEY_ADDR == RST_ADDR) $error("key and reset register addresses collide");
    end

endmodule

// File: rtl/swr_key_seq.sv
module swr_key_seq
    import swr_pkg::*;
#(
    parameter logic [KEY_LEN*DATA_W-1:0] KEY_SEQ = KEY_SEQ_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    output logic    unlocked
);

    localparam int unsigned       STG_W   = $clog2(KEY_LEN + 1);
    localparam logic [STG_W-1:0]  OPEN_ST = STG_W'(KEY_LEN);
    localparam logic [STG_W-1:0]  LAST_ST = STG_W'(KEY_LEN - 1);
    localparam logic [STG_W-1:0]  IDLE_ST = '0;
    localparam logic [STG_W-1:0]  ONE_ST  = STG_W'(1);

    logic [STG_W-1:0]   stage_q;
    logic [STG_W-1:0]   stage_d;
    logic [KEY_LEN-1:0] hit;
    logic               advance;
    logic               first_key;

    // one comparator per key position, enabled only at its own stage
    for (genvar i = 0; i < KEY_LEN; i++) begin : g_key_cmp
        localparam logic [DATA_W-1:0] KEY_I = key_byte(KEY_SEQ, i);
        assign hit[i] = (stage_q == STG_W'(i)) && (cmd.data == KEY_I);
    end

    assign advance   = |hit;
    assign first_key = (cmd.data == key_byte(KEY_SEQ, 0));

    always_comb begin
        stage_d = stage_q;
        if (cmd.key_wr) begin
            if (advance)        stage_d = stage_q + ONE_ST;
            else if (first_key) stage_d = ONE_ST;
            else                stage_d = IDLE_ST;
        end else if (cmd.rst_wr && (stage_q == OPEN_ST)) begin
            stage_d = IDLE_ST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= IDLE_ST;
        else     stage_q <= stage_d;
    end

    assign unlocked = (stage_q == OPEN_ST);

    // R2
    unlock_order_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_q == OPEN_ST) |-> ($past(stage_q) == LAST_ST || $past(stage_q) == OPEN_ST));

    // R6
    lock_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && cmd.rst_wr) |=> !unlocked);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd.key_wr && !(cmd.rst_wr && unlocked)) |=> $stable(stage_q));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.key_wr && first_key) |=> (stage_q != IDLE_ST));

endmodule

// File: rtl/swr_fire_reg.sv
module swr_fire_reg
    import swr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FIRE_VAL = FIRE_VAL_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  logic    unlocked,
    output logic    fire
);

    logic [DATA_W-1:0] ctl_q;
    logic              armed;
    logic              take;

    assign armed = (ctl_q == FIRE_VAL);
    assign take  = cmd.rst_wr && unlocked && (cmd.data == FIRE_VAL) && !armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            fire  <= 1'b0;
        end else begin
            if (take) ctl_q <= FIRE_VAL;
            fire <= take;
        end
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(unlocked && cmd.rst_wr && cmd.data == FIRE_VAL));

    // R7
    armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        armed |=> (armed && !fire));

endmodule

// File: rtl/swr_unlock_top.sv
module swr_unlock_top
    import swr_pkg::*;
#(
    parameter logic [ADDR_W-1:0]         KEY_ADDR = KEY_ADDR_DEF,
    parameter logic [ADDR_W-1:0]         RST_ADDR = RST_ADDR_DEF,
    parameter logic [DATA_W-1:0]         FIRE_VAL = FIRE_VAL_DEF,
    parameter logic [KEY_LEN*DATA_W-1:0] KEY_SEQ  = KEY_SEQ_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sw_rst_req
);

    wr_cmd_t cmd;
    logic    unlocked;

    swr_wr_decode #(
        .KEY_ADDR (KEY_ADDR),
        .RST_ADDR (RST_ADDR)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    swr_key_seq #(
        .KEY_SEQ (KEY_SEQ)
    ) u_key (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .unlocked (unlocked)
    );

    swr_fire_reg #(
        .FIRE_VAL (FIRE_VAL)
    ) u_fire (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .unlocked (unlocked),
        .fire     (sw_rst_req)
    );

    // R1
    post_reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sw_rst_req && !unlocked));

endmodule

// File: tb/tb_swr_unlock_top.sv
module tb_swr_unlock_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sw_rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [7:0] KA = 8'hF7;
    localparam logic [7:0] RA = 8'hE7;

    always #10 clk = ~clk;

    swr_unlock_top dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sw_rst_req (sw_rst_req)
    );

    task automatic chk(input bit act, input bit exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: sw_rst_req actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        chk(sw_rst_req, 1'b0, "R1 during reset");
        rst = 1'b0;
    endtask

    // returns at the negedge just after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit en = 1'b1);
        @(negedge clk);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(KA, 8'h55);
        wr(KA, 8'hAA);
        wr(KA, 8'h5A);
    endtask

    // write FFh to the reset register and check the request and its width
    task automatic fire_check(input bit exp, input string tag);
        wr(RA, 8'hFF);
        chk(sw_rst_req, exp, tag);
        @(negedge clk);
        chk(sw_rst_req, 1'b0, "R5 pulse width");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        chk(sw_rst_req, 1'b0, "R1 after reset");
        // R1: locked after reset
        fire_check(1'b0, "R1 locked after reset");

        // R2: sweep each key position over all byte values
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(KA, 8'(v)); wr(KA, 8'hAA); wr(KA, 8'h5A);
            fire_check(v == 8'h55, "R2 first key sweep");
        end
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(KA, 8'h55); wr(KA, 8'(v)); wr(KA, 8'h5A);
            fire_check(v == 8'hAA, "R2 second key sweep");
        end
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'(v));
            fire_check(v == 8'h5A, "R2 third key sweep");
        end

        // R6: sweep the value of the unlocked reset register write
        for (int v = 0; v < 256; v++) begin
            do_reset();
            unlock();
            wr(RA, 8'(v));
            chk(sw_rst_req, v == 8'hFF, "R6 reset value sweep");
            if (v != 8'hFF) fire_check(1'b0, "R6 unlock consumed");
        end

        // R3: broken series, restart on first key
        do_reset();
        wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
        fire_check(1'b1, "R3 restart after break at third key");
        do_reset();
        wr(KA, 8'h55); wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
        fire_check(1'b1, "R3 repeated first key");
        do_reset();
        wr(KA, 8'h55); wr(KA, 8'h12); wr(KA, 8'hAA); wr(KA, 8'h5A);
        fire_check(1'b0, "R3 break returns to idle");
        do_reset();
        unlock();
        wr(KA, 8'h00);
        fire_check(1'b0, "R3 key write while open relocks");

        // R4: other addresses and locked reset writes are ignored
        do_reset();
        wr(KA, 8'h55);
        wr(8'h10, 8'h00);
        wr(RA, 8'hFF);
        chk(sw_rst_req, 1'b0, "R4 locked reset write ignored");
        wr(8'hF6, 8'h5A);
        wr(KA, 8'hAA);
        wr(8'hE6, 8'hFF);
        chk(sw_rst_req, 1'b0, "R4 neighbour address ignored");
        wr(KA, 8'h5A);
        fire_check(1'b1, "R4 series survives other writes");

        // R9: strobe low is no write
        do_reset();
        wr(KA, 8'h55, 1'b0); wr(KA, 8'hAA); wr(KA, 8'h5A);
        fire_check(1'b0, "R9 key write without strobe");
        do_reset();
        unlock();
        wr(RA, 8'hFF, 1'b0);
        chk(sw_rst_req, 1'b0, "R9 reset write without strobe");
        fire_check(1'b1, "R9 unlock kept past strobe-low cycle");

        // R7: fired register holds, no second request
        unlock();
        fire_check(1'b0, "R7 no refire before reset");
        repeat (5) begin
            @(negedge clk);
            chk(sw_rst_req, 1'b0, "R7 request stays low");
        end
        do_reset();
        unlock();
        fire_check(1'b1, "R7 reset clears fired register");

        // R8: reset discards unlock and partial series
        do_reset();
        unlock();
        do_reset();
        fire_check(1'b0, "R8 unlock lost on reset");
        do_reset();
        wr(KA, 8'h55); wr(KA, 8'hAA);
        do_reset();
        wr(KA, 8'h5A);
        fire_check(1'b0, "R8 partial series lost on reset");

        finish_run();
    end

endmodule